// File: doc/BRIEF.md
# Text-Mode Character Overlay Generator

This block paints a small grid of numeric characters on a 640x480 raster. An external sync generator supplies the current pixel row and column. The block works out which character cell the pixel falls in and reads that cell's 4-bit value from an internal cell store. It turns the value into a 6-bit glyph code, fetches the matching 8-pixel font row, and picks the bit for the current pixel column. The result is a single pixel-on bit, which downstream logic can mix into the colour outputs.

Other logic fills the cell store through a one-cycle write port that takes a cell row, a cell column and a 4-bit value. The grid is 20 cells wide and 6 cells tall and sits in the top-left corner of the screen. Each cell is 8x8 pixels, and the block runs on the pixel clock. The two pipeline stages, cell read and font read, give a fixed delay of two clocks from a coordinate to its pixel bit.

Top module: `text_overlay_gen`

## Requirements
- R1: While rst_n is low at a clock edge, pixel_on is 0 after that edge. Reset clears every cell value to 0, so a freshly reset grid shows the digit-0 glyph in every cell.
- R2: The pixel_on value for coordinates held at the inputs before clock edge k appears after edge k+1, which is two edges later. A new coordinate may be applied every cycle.
- R3: The cell row is pix_row[8:3] and the cell column is pix_col[8:3]. Within the cell, the glyph row is pix_row[2:0] and the glyph column is pix_col[2:0]. Glyph column 0 uses bit 7 of the font row, which is the leftmost pixel.
- R4: A cell value v from 0 to 9 selects glyph code 32+v, a seven-segment digit. In that glyph, row 0 is 00111100 when segment a is lit; rows 1-2 are f->01000000 OR b->00000010; row 3 is g->00111100; rows 4-5 are e->01000000 OR c->00000010; row 6 is d->00111100; row 7 is 0. The lit segments for each digit are: 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 acdefg, 7 abc, 8 abcdefg, 9 abcdfg.
- R5: A cell value v from 10 to 15 selects glyph code v-9, so value 10 selects code 1. Code 1 is the letter A, with rows top to bottom 00011000, 00111100, 01100110, 01111110, 01100110, 01100110, 01100110, 00000000.
- R6: Glyph codes other than 1 and 32 to 41 are blank, so values 11 to 15 light no pixel.
- R7: A pixel whose cell row is 6 or more, whose cell column is 20 or more, or whose coordinate has bit 9 set, gives pixel_on = 0. This holds even though its low bits would alias onto a stored cell.
- R8: A pixel outside the visible 640x480 area gives pixel_on = 0.
- R9: A write with wr_en high stores wr_val at (wr_row, wr_col) at the next edge, and a read after that edge returns it. A write whose row is 6 or more or whose column is 20 or more changes no cell.
- R10: When a cell is read in the same cycle it is written, the read returns the value the cell held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_row | input | 10 | Current raster line from the sync generator |
| pix_col | input | 10 | Current pixel within the line |
| wr_en | input | 1 | Write strobe for the cell store |
| wr_row | input | 6 | Cell row to write |
| wr_col | input | 6 | Cell column to write |
| wr_val | input | 4 | Value stored in the addressed cell |
| pixel_on | output | 1 | 1 when the pixel is lit, two clocks after its coordinate |

## Verification
Every pixel of cells holding each digit 0 to 9 is compared against the segment rules. This separates a wrong segment mask, a wrong digit offset, and a row or column flipped inside the glyph. Value 10 is scanned against the letter pattern and values 11 to 15 against a blank cell, which shows whether the letter offset and the blank fallback are right. A run of one new column per cycle across a whole cell row exposes any misaligned pipeline delay that a held coordinate would hide. Probes just past the grid edges, at aliasing columns with bit 9 set, at off-screen coordinates, after out-of-range writes and during same-cycle read and write tell masking faults apart from store faults.

// File: rtl/ovl_pkg.sv
// Shared types and glyph-code constants for the character overlay.
// Assumes 8x8 glyphs and 4-bit cell values.
package ovl_pkg;
    localparam int GLYPH_BITS = 3;
    localparam int GLYPH_W    = 8;

    typedef logic [3:0]         cell_val_t;
    typedef logic [5:0]         glyph_code_t;
    typedef logic [GLYPH_W-1:0] glyph_row_t;

    localparam glyph_code_t DIGIT_BASE  = 6'd32;
    localparam glyph_code_t LETTER_BASE = 6'd1;
    localparam cell_val_t   FIRST_HEX   = 4'd10;
endpackage

// File: rtl/ovl_cell_store.sv
// Cell store: ROWS x COLS array of 4-bit values held in flops and cleared on reset.
// It has one write port and one registered read port, and a read of a cell
// being written returns the old value.
// Assumes out-of-range addresses must never alias onto a stored cell.
module ovl_cell_store
    import ovl_pkg::*;
#(
    parameter int ROWS   = 6,
    parameter int COLS   = 20,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_row,
    input  logic [ADDR_W-1:0] wr_col,
    input  cell_val_t         wr_val,
    input  logic [ADDR_W-1:0] rd_row,
    input  logic [ADDR_W-1:0] rd_col,
    output cell_val_t         rd_val_q
);
    localparam int DEPTH = ROWS * COLS;
    localparam int IW    = $clog2(DEPTH);
    localparam logic [ADDR_W-1:0] ROWS_L = ADDR_W'(ROWS);
    localparam logic [ADDR_W-1:0] COLS_L = ADDR_W'(COLS);

    cell_val_t      cells [DEPTH];
    logic           wr_ok, rd_ok;
    logic [IW-1:0]  wr_idx, rd_idx;
    cell_val_t      cur_val;

    // Range check and linear index for both ports.
    always_comb begin
        wr_ok   = (wr_row < ROWS_L) && (wr_col < COLS_L);
        rd_ok   = (rd_row < ROWS_L) && (rd_col < COLS_L);
        wr_idx  = IW'(wr_row * COLS + wr_col);
        rd_idx  = IW'(rd_row * COLS + rd_col);
        cur_val = rd_ok ? cells[rd_idx] : '0;
    end

    // Cell array: cleared on reset, one in-range write per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (wr_en && wr_ok) begin
            cells[wr_idx] <= wr_val;
        end
    end

    // Registered read, sampled before any same-edge write lands.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_val_q <= '0;
        else        rd_val_q <= cur_val;
    end

    // R9: an in-range write is present in the array after the edge.
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ok) |=> (cells[$past(wr_idx)] == $past(wr_val)));

    // R10: reading the cell being written returns its previous content.
    assert_read_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ok && rd_ok && (rd_idx == wr_idx)) |=> (rd_val_q == $past(cur_val)));
endmodule

// File: rtl/ovl_glyph_map.sv
// Value-to-glyph converter: digits 0-9 go to the digit block and 10-15 to the
// letter block starting at the letter A.
// Purely combinational; assumes the font places these blocks at the package bases.
module ovl_glyph_map
    import ovl_pkg::*;
(
    input  cell_val_t   val,
    output glyph_code_t code
);
    // Select the glyph block and add the offset within it.
    always_comb begin
        if (val < FIRST_HEX) code = DIGIT_BASE + glyph_code_t'(val);
        else                 code = LETTER_BASE + glyph_code_t'(val - FIRST_HEX);
    end
endmodule

// File: rtl/ovl_font_rom.sv
// Font memory: 64 glyphs of 8 rows x 8 bits with a registered read. The glyph
// contents are computed, not stored as a table. Code 1 is the letter A,
// codes 32-41 are seven-segment digits, and every other code is blank.
// Assumes the word address is {code, glyph row}.
module ovl_font_rom
    import ovl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  glyph_code_t           code,
    input  logic [GLYPH_BITS-1:0] grow,
    output glyph_row_t            row_q
);
    // Segment set {a,b,c,d,e,f,g} for one decimal digit.
    function automatic logic [6:0] seg_set(input logic [3:0] d);
        case (d)
            4'd0:    seg_set = 7'b1111110;
            4'd1:    seg_set = 7'b0110000;
            4'd2:    seg_set = 7'b1101101;
            4'd3:    seg_set = 7'b1111001;
            4'd4:    seg_set = 7'b0110011;
            4'd5:    seg_set = 7'b1011011;
            4'd6:    seg_set = 7'b1011111;
            4'd7:    seg_set = 7'b1110000;
            4'd8:    seg_set = 7'b1111111;
            default: seg_set = 7'b1111011;
        endcase
    endfunction

    // Font row for one glyph code and row number.
    function automatic glyph_row_t font_word(input glyph_code_t c, input logic [2:0] r);
        logic [6:0] s;
        glyph_row_t w;
        w = '0;
        if (c == LETTER_BASE) begin
            case (r)
                3'd0:    w = 8'b00011000;
                3'd1:    w = 8'b00111100;
                3'd3:    w = 8'b01111110;
                3'd7:    w = 8'b00000000;
                default: w = 8'b01100110;
            endcase
        end else if (c >= DIGIT_BASE && c < DIGIT_BASE + 6'd10) begin
            s = seg_set(4'(c - DIGIT_BASE));
            case (r)
                3'd0:       w = s[6] ? 8'b00111100 : 8'b0;
                3'd1, 3'd2: w = (s[1] ? 8'b01000000 : 8'b0) | (s[5] ? 8'b00000010 : 8'b0);
                3'd3:       w = s[0] ? 8'b00111100 : 8'b0;
                3'd4, 3'd5: w = (s[2] ? 8'b01000000 : 8'b0) | (s[4] ? 8'b00000010 : 8'b0);
                3'd6:       w = s[3] ? 8'b00111100 : 8'b0;
                default:    w = 8'b0;
            endcase
        end
        return w;
    endfunction

    // Registered font read.
    always_ff @(posedge clk) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= font_word(code, grow);
    end

    // R6: codes outside the letter and digit blocks read back blank.
    assert_blank_codes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((code != LETTER_BASE) && ((code < DIGIT_BASE) || (code > DIGIT_BASE + 6'd9)))
        |=> (row_q == '0));
endmodule

// File: rtl/text_overlay_gen.sv
// Character overlay top. It maps a raster coordinate to a cell, reads the cell
// value, converts it to a glyph code, reads the font row and selects the pixel bit.
// Latency is two clocks. Assumes coordinates come from an external sync
// generator and advance on the same clock.
module text_overlay_gen
    import ovl_pkg::*;
#(
    parameter int H_ACTIVE  = 640,
    parameter int V_ACTIVE  = 480,
    parameter int CELL_COLS = 20,
    parameter int CELL_ROWS = 6,
    parameter int COORD_W   = 10,
    parameter int ADDR_W    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] pix_row,
    input  logic [COORD_W-1:0] pix_col,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_row,
    input  logic [ADDR_W-1:0]  wr_col,
    input  logic [3:0]         wr_val,
    output logic               pixel_on
);
    localparam int HI = GLYPH_BITS + ADDR_W;
    localparam logic [ADDR_W-1:0] ROWS_L = ADDR_W'(CELL_ROWS);
    localparam logic [ADDR_W-1:0] COLS_L = ADDR_W'(CELL_COLS);

    logic [ADDR_W-1:0]     cell_r, cell_c;
    logic                  in_win;
    logic                  s1_on, s2_on;
    logic [GLYPH_BITS-1:0] s1_grow, s1_gcol, s2_gcol;
    cell_val_t             cell_val;
    glyph_code_t           code;
    glyph_row_t            font_row;

    // Split the coordinate and decide whether it lands on the grid.
    always_comb begin
        cell_r = pix_row[GLYPH_BITS +: ADDR_W];
        cell_c = pix_col[GLYPH_BITS +: ADDR_W];
        in_win = (pix_row < COORD_W'(V_ACTIVE)) && (pix_col < COORD_W'(H_ACTIVE))
              && ((pix_row >> HI) == '0) && ((pix_col >> HI) == '0)
              && (cell_r < ROWS_L) && (cell_c < COLS_L);
    end

    ovl_cell_store #(.ROWS(CELL_ROWS), .COLS(CELL_COLS), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_val(wr_val),
        .rd_row(cell_r), .rd_col(cell_c), .rd_val_q(cell_val)
    );

    ovl_glyph_map u_map (.val(cell_val), .code(code));

    ovl_font_rom u_font (
        .clk(clk), .rst_n(rst_n), .code(code), .grow(s1_grow), .row_q(font_row)
    );

    // Carry the window flag and the glyph position alongside the two reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_on   <= 1'b0;
            s1_grow <= '0;
            s1_gcol <= '0;
            s2_on   <= 1'b0;
            s2_gcol <= '0;
        end else begin
            s1_on   <= in_win;
            s1_grow <= pix_row[GLYPH_BITS-1:0];
            s1_gcol <= pix_col[GLYPH_BITS-1:0];
            s2_on   <= s1_on;
            s2_gcol <= s1_gcol;
        end
    end

    // Column 0 of a glyph is bit 7 of its font row.
    assign pixel_on = s2_on & font_row[(GLYPH_W-1) - int'(s2_gcol)];

    // R1: reset darkens the output after the edge.
    assert_reset_dark_R1: assert property (@(posedge clk)
        !rst_n |=> !pixel_on);

    // R7/R8: a coordinate off the grid or off screen gives a dark pixel two clocks later.
    assert_dark_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_win |-> ##2 !pixel_on);
endmodule

// File: tb/test_text_overlay_gen.sv
module test_text_overlay_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] pix_row = '0, pix_col = '0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_row = '0, wr_col = '0;
    logic [3:0] wr_val = '0;
    logic       pixel_on;

    int checks = 0;
    int failures = 0;
    logic [3:0] shadow [6][20];

    always #5 clk = ~clk;

    text_overlay_gen i_text_overlay_gen (
        .clk(clk), .rst_n(rst_n), .pix_row(pix_row), .pix_col(pix_col),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_val(wr_val),
        .pixel_on(pixel_on)
    );

    // Expected glyph row from the requirement text (R4, R5, R6).
    function automatic logic [7:0] ref_row(input int v, input int r);
        logic [6:0] s;
        logic [7:0] w;
        w = 8'h00;
        if (v == 10) begin
            case (r)
                0: w = 8'b00011000; 1: w = 8'b00111100; 2: w = 8'b01100110;
                3: w = 8'b01111110; 4: w = 8'b01100110; 5: w = 8'b01100110;
                6: w = 8'b01100110; default: w = 8'b00000000;
            endcase
        end else if (v < 10) begin
            case (v)
                0: s = 7'b1111110; 1: s = 7'b0110000; 2: s = 7'b1101101;
                3: s = 7'b1111001; 4: s = 7'b0110011; 5: s = 7'b1011011;
                6: s = 7'b1011111; 7: s = 7'b1110000; 8: s = 7'b1111111;
                default: s = 7'b1111011;
            endcase
            if (r == 0 && s[6]) w = 8'b00111100;
            if ((r == 1 || r == 2) && s[1]) w = w | 8'b01000000;
            if ((r == 1 || r == 2) && s[5]) w = w | 8'b00000010;
            if (r == 3 && s[0]) w = 8'b00111100;
            if ((r == 4 || r == 5) && s[2]) w = w | 8'b01000000;
            if ((r == 4 || r == 5) && s[4]) w = w | 8'b00000010;
            if (r == 6 && s[3]) w = 8'b00111100;
        end
        return w;
    endfunction

    // Expected pixel for a coordinate (R3, R7, R8).
    function automatic logic exp_pix(input int r, input int c);
        logic [7:0] w;
        if (r >= 480 || c >= 640) return 1'b0;
        if (r / 8 >= 6 || c / 8 >= 20) return 1'b0;
        w = ref_row(int'(shadow[r/8][c/8]), r % 8);
        return w[7 - (c % 8)];
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic probe(input int r, input int c, output logic v);
        @(negedge clk);
        pix_row = 10'(r);
        pix_col = 10'(c);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        v = pixel_on;
    endtask

    task automatic probe_check(input string req, input int r, input int c);
        logic v;
        probe(r, c, v);
        check(req, $sformatf("pixel(%0d,%0d)", r, c), int'(v), int'(exp_pix(r, c)));
    endtask

    task automatic do_write(input int r, input int c, input int v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_row = 6'(r);
        wr_col = 6'(c);
        wr_val = 4'(v);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        if (r < 6 && c < 20) shadow[r][c] = 4'(v);
    endtask

    task automatic scan_cell(input string req, input int cr, input int cc);
        for (int fr = 0; fr < 8; fr++)
            for (int fc = 0; fc < 8; fc++)
                probe_check(req, cr * 8 + fr, cc * 8 + fc);
    endtask

    // R1: dark during reset, digit 0 everywhere afterwards.
    task automatic t_reset;
        pix_row = 10'd0;
        pix_col = 10'd2;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1", "pixel_on in reset", int'(pixel_on), 0);
        rst_n = 1'b1;
        probe_check("R1", 0, 2);
        check("R1", "cleared cell lit", int'(exp_pix(0, 2)), 1);
        probe_check("R1", 40, 154);
        scan_cell("R1", 5, 19);
    endtask

    // R3/R4: every digit, every pixel.
    task automatic t_digits;
        for (int d = 0; d < 10; d++) do_write(1, d, d);
        for (int d = 0; d < 10; d++) scan_cell("R4", 1, d);
    endtask

    // R5/R6: letter A and blank codes.
    task automatic t_letters;
        for (int v = 10; v < 16; v++) do_write(2, v - 10, v);
        scan_cell("R5", 2, 0);
        for (int v = 11; v < 16; v++) scan_cell("R6", 2, v - 10);
    endtask

    // R2: new column every cycle, output two cycles later.
    task automatic t_stream;
        for (int i = 0; i < 162; i++) begin
            @(negedge clk);
            if (i >= 2)
                check("R2", $sformatf("stream col %0d", i - 2), int'(pixel_on),
                      int'(exp_pix(11, i - 2)));
            pix_row = 10'd11;
            if (i < 160) pix_col = 10'(i);
        end
    endtask

    // R7/R8: grid edges, aliasing columns, off-screen coordinates.
    task automatic t_region;
        logic v;
        probe(0, 162, v);  check("R7", "column past grid", int'(v), 0);
        probe(50, 2, v);   check("R7", "row past grid", int'(v), 0);
        probe(0, 514, v);  check("R7", "bit9 column alias", int'(v), 0);
        probe(8, 600, v);  check("R7", "visible alias col", int'(v), 0);
        probe(500, 2, v);  check("R8", "below screen", int'(v), 0);
        probe(0, 700, v);  check("R8", "right of screen", int'(v), 0);
        probe(0, 2, v);    check("R8", "control lit pixel", int'(v), 1);
    endtask

    // R9: stores land, out-of-range writes change nothing.
    task automatic t_writes;
        do_write(0, 20, 8);
        do_write(6, 0, 8);
        do_write(63, 63, 8);
        scan_cell("R9", 1, 0);
        scan_cell("R9", 5, 19);
        probe_check("R9", 0, 162);
        do_write(4, 7, 8);
        scan_cell("R9", 4, 7);
    endtask

    // R10: read of the cell being written returns the old value.
    task automatic t_read_first;
        logic v;
        @(negedge clk);
        pix_row = 10'd24;
        pix_col = 10'd2;
        wr_en = 1'b1;
        wr_row = 6'd3;
        wr_col = 6'd0;
        wr_val = 4'd1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R10", "same-cycle read old digit 0", int'(pixel_on), 1);
        shadow[3][0] = 4'd1;
        probe(24, 2, v);
        check("R10", "later read new digit 1", int'(v), 0);
    endtask

    initial begin
        for (int r = 0; r < 6; r++)
            for (int c = 0; c < 20; c++) shadow[r][c] = 4'd0;
        t_reset;
        t_digits;
        t_letters;
        t_stream;
        t_region;
        t_writes;
        t_read_first;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule